// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address for each beat of a short burst into a synchronous memory. A burst opens when either of two active-low start strobes is sampled low. One strobe always opens a read burst. The other opens a read or a write burst, as a request input selects. On that edge the block captures the full start address and latches the burst order from a mode pin. It also latches the kind of burst.

After the burst opens, an active-low advance input steps an internal beat counter. The address output keeps the upper bits captured at the start. Its low bits follow one of two orders. The interleaved order XORs the start low bits with the beat count. The linear order adds the beat count to the start low bits, modulo the burst length. In a write burst a beat counts only when its byte-write strobe is also low, so idle write beats do not move the address. The sequence wraps to the start address after the last beat and raises no flag.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `burst_addr` is zero. The state after reset behaves as a linear read burst that starts at address 0.
- R2: When `proc_start_n` or `ctrl_start_n` is low on a rising edge, `burst_addr` equals the `start_addr` sampled on that edge from the next cycle on. If both are low, `proc_start_n` wins and the burst is a read.
- R3: `adv_n` and `byte_wr_n` are not sampled on an edge that loads a start address. The first beat after a load always sits at the start address.
- R4: The address moves only on an edge where `adv_n` is low and both start strobes are high. On every other non-load edge it holds.
- R5: A burst loaded with `order_sel` = 1 (interleaved) presents low bits equal to the start low bits XOR the beat count. From a start of 1 this gives 1, 0, 3, 2.
- R6: A burst loaded with `order_sel` = 0 (linear) presents low bits equal to the start low bits plus the beat count, modulo 2^BEAT_W. From a start of 1 this gives 1, 2, 3, 0.
- R7: Address bits above the low BEAT_W bits never change except on a load edge.
- R8: After 2^BEAT_W advances the address is back at the start address, and no other output changes.
- R9: `ctrl_start_n` low with `proc_start_n` high and `wr_req_n` low opens a write burst. In a write burst, an edge with `adv_n` low advances only if `byte_wr_n` is also low.
- R10: `wr_req_n` is ignored on a load by `proc_start_n`. That burst is a read, and a read burst advances on `adv_n` low whatever `byte_wr_n` is.
- R11: `order_sel` is sampled only on a load edge. Changing it during a burst leaves the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_start_n | input | 1 | Active-low strobe that opens a read burst |
| ctrl_start_n | input | 1 | Active-low strobe that opens a read or write burst |
| wr_req_n | input | 1 | Active-low write request, sampled with `ctrl_start_n` |
| start_addr | input | ADDR_W | Start address of a new burst |
| adv_n | input | 1 | Active-low burst advance |
| byte_wr_n | input | 1 | Active-low byte-write strobe that gates advances in a write burst |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| burst_addr | output | ADDR_W | Current beat address |

## Verification
The checker tests the properties that span one cycle, on every cycle:
- the next address after a load is the captured start address (R2);
- the beat restarts from zero after a load (R3);
- the address holds when there is neither a load nor an advance (R4);
- strobes block advancing (R4);
- the upper bits stay stable (R7);
- the beat steps by one (R8);
- in a write burst, a beat with its byte strobe high is blocked (R9).

Only the bench's scenarios can show the actual beat orders of the two modes (R5, R6) and the return to the start address after a full cycle of beats (R8). The same holds for mode capture against a mid-burst change of `order_sel` (R11) and for read bursts ignoring the write request (R10). The bench's behavioural model shows these by comparing the address on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Burst ordering latched at load time.
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_INTLV  = 1'b1
  } order_e;

  // Direction of the burst latched at load time.
  typedef enum logic {
    KIND_READ  = 1'b0,
    KIND_WRITE = 1'b1
  } kind_e;

  // Widest low-bit field the helper functions support.
  localparam int unsigned SEQ_MAX_W = 8;

  // Mask of the w least-significant bits.
  function automatic logic [SEQ_MAX_W-1:0] low_mask(input int unsigned w);
    logic [SEQ_MAX_W:0] full;
    full = (SEQ_MAX_W+1)'(1) << w;
    return SEQ_MAX_W'(full - (SEQ_MAX_W+1)'(1));
  endfunction

  // Interleaved order: start bits flipped by the beat number.
  function automatic logic [SEQ_MAX_W-1:0] intlv_low(
    input logic [SEQ_MAX_W-1:0] start,
    input logic [SEQ_MAX_W-1:0] beat,
    input int unsigned          w
  );
    return (start ^ beat) & low_mask(w);
  endfunction

  // Linear order: start plus beat, wrapping at 2^w.
  function automatic logic [SEQ_MAX_W-1:0] linear_low(
    input logic [SEQ_MAX_W-1:0] start,
    input logic [SEQ_MAX_W-1:0] beat,
    input int unsigned          w
  );
    return (start + beat) & low_mask(w);
  endfunction

  // Selects between the two orders.
  function automatic logic [SEQ_MAX_W-1:0] seq_low(
    input logic [SEQ_MAX_W-1:0] start,
    input logic [SEQ_MAX_W-1:0] beat,
    input order_e               ord,
    input int unsigned          w
  );
    return (ord == ORDER_INTLV) ? intlv_low(start, beat, w)
                                : linear_low(start, beat, w);
  endfunction

endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
  import burst_seq_pkg::*;
(
  input  logic  proc_start_n,
  input  logic  ctrl_start_n,
  input  logic  wr_req_n,
  input  logic  adv_n,
  input  logic  byte_wr_n,
  input  kind_e cur_kind,
  output logic  load_evt,
  output kind_e load_kind,
  output logic  adv_evt
);

  logic proc_load;
  logic ctrl_load;
  logic strobes_idle;
  logic beat_qualified;

  // The read-only strobe has priority over the general strobe.
  assign proc_load = !proc_start_n;
  assign ctrl_load = proc_start_n && !ctrl_start_n;
  assign load_evt  = proc_load || ctrl_load;

  // A write request counts only on a load by the general strobe.
  always_comb begin
    load_kind = KIND_READ;
    if (ctrl_load && !wr_req_n) load_kind = KIND_WRITE;
  end

  // Advances are blocked while either strobe is low.
  assign strobes_idle = proc_start_n && ctrl_start_n;

  // A write beat steps only when its byte strobe is active.
  assign beat_qualified = (cur_kind == KIND_READ) || !byte_wr_n;

  assign adv_evt = strobes_idle && !adv_n && beat_qualified;

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              adv_evt,
  output logic [BEAT_W-1:0] beat_q
);

  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] beat_d;

  // A load restarts the burst; an advance steps and wraps naturally.
  always_comb begin
    beat_d = beat_q;
    if (load_evt)     beat_d = '0;
    else if (adv_evt) beat_d = beat_q + BEAT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

endmodule

// File: rtl/burst_origin_reg.sv
module burst_origin_reg
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic [ADDR_W-1:0]  start_addr,
  input  order_e             load_order,
  input  kind_e              load_kind,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output logic [BEAT_W-1:0]  start_low_q,
  output order_e             order_q,
  output kind_e              kind_q
);

  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

  // Everything about the burst is captured once, on the load edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q     <= '0;
      start_low_q <= '0;
      order_q     <= ORDER_LINEAR;
      kind_q      <= KIND_READ;
    end else if (load_evt) begin
      upper_q     <= start_addr[ADDR_W-1 -: UPPER_W];
      start_low_q <= start_addr[BEAT_W-1:0];
      order_q     <= load_order;
      kind_q      <= load_kind;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              wr_req_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              adv_n,
  input  logic              byte_wr_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] burst_addr
);

  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

  // Named internal events, visible to the bound checker.
  logic               load_evt;
  logic               adv_evt;
  kind_e              load_kind;
  kind_e              kind_q;
  order_e             order_q;
  order_e             load_order;
  logic [BEAT_W-1:0]  beat_q;
  logic [BEAT_W-1:0]  start_low_q;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  low_bits;

  assign load_order = order_e'(order_sel);

  burst_strobe_decode u_decode (
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .wr_req_n     (wr_req_n),
    .adv_n        (adv_n),
    .byte_wr_n    (byte_wr_n),
    .cur_kind     (kind_q),
    .load_evt     (load_evt),
    .load_kind    (load_kind),
    .adv_evt      (adv_evt)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .beat_q   (beat_q)
  );

  burst_origin_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_origin (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_evt    (load_evt),
    .start_addr  (start_addr),
    .load_order  (load_order),
    .load_kind   (load_kind),
    .upper_q     (upper_q),
    .start_low_q (start_low_q),
    .order_q     (order_q),
    .kind_q      (kind_q)
  );

  // The low-bit path is built per width range that the helpers support.
  generate
    if (BEAT_W <= SEQ_MAX_W) begin : g_low_fn
      logic [SEQ_MAX_W-1:0] low_wide;
      always_comb begin
        low_wide = seq_low(SEQ_MAX_W'(start_low_q), SEQ_MAX_W'(beat_q),
                           order_q, BEAT_W);
      end
      assign low_bits = low_wide[BEAT_W-1:0];
    end else begin : g_low_direct
      assign low_bits = (order_q == ORDER_INTLV) ? (start_low_q ^ beat_q)
                                                 : (start_low_q + beat_q);
    end
  endgenerate

  assign burst_addr = {upper_q, low_bits};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_start_n,
  input logic              ctrl_start_n,
  input logic              byte_wr_n,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] burst_addr,
  input logic              load_evt,
  input logic              adv_evt,
  input kind_e             kind_q,
  input logic [BEAT_W-1:0] beat_q
);

  // Set one edge after reset is released, so no $past reaches into reset.
  logic armed_q;
  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && load_evt) |=> (burst_addr == $past(start_addr)));

  assert_load_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && load_evt) |=> (beat_q == '0));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !load_evt && !adv_evt) |=> $stable(burst_addr));

  assert_strobe_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_start_n || !ctrl_start_n) |-> !adv_evt);

  assert_upper_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !load_evt) |=> $stable(burst_addr[ADDR_W-1:BEAT_W]));

  assert_beat_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && adv_evt) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));

  assert_write_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == KIND_WRITE && byte_wr_n && !load_evt) |-> !adv_evt);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .proc_start_n (proc_start_n),
  .ctrl_start_n (ctrl_start_n),
  .byte_wr_n    (byte_wr_n),
  .start_addr   (start_addr),
  .burst_addr   (burst_addr),
  .load_evt     (load_evt),
  .adv_evt      (adv_evt),
  .kind_q       (kind_q),
  .beat_q       (beat_q)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int BW = 2;
  localparam int NB = 4;
  localparam int WATCHDOG_CYCLES = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_start_n = 1'b1;
  logic          ctrl_start_n = 1'b1;
  logic          wr_req_n = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic          adv_n = 1'b1;
  logic          byte_wr_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] burst_addr;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .wr_req_n     (wr_req_n),
    .start_addr   (start_addr),
    .adv_n        (adv_n),
    .byte_wr_n    (byte_wr_n),
    .order_sel    (order_sel),
    .burst_addr   (burst_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errs   = 0;

  // Behavioural reference: the burst as a list of beat offsets.
  int m_base  = 0;
  int m_order[$];
  int m_pos   = 0;
  bit m_write = 0;

  function automatic void model_start(int addr, bit intlv, bit wr);
    int s;
    s = addr % NB;
    m_base = addr - s;
    m_order.delete();
    for (int k = 0; k < NB; k++) begin
      if (intlv) m_order.push_back(s ^ k);
      else       m_order.push_back((s + k) % NB);
    end
    m_pos = 0;
    m_write = wr;
  endfunction

  function automatic int model_addr();
    return m_base + m_order[m_pos];
  endfunction

  task automatic check(string tag);
    n_checks++;
    if (burst_addr !== AW'(model_addr())) begin
      n_errs++;
      $display("FAIL %s: burst_addr=%0h expected %0h", tag, burst_addr, model_addr());
    end
  endtask

  // Drives one cycle after a falling edge, advances the model, and checks at the next falling edge.
  task automatic step(bit ps, bit cs, bit wr, int addr, bit adv, bit bwr, bit md, string tag);
    proc_start_n = ps;
    ctrl_start_n = cs;
    wr_req_n     = wr;
    start_addr   = AW'(addr);
    adv_n        = adv;
    byte_wr_n    = bwr;
    order_sel    = md;
    if (!ps)      model_start(addr, md, 1'b0);
    else if (!cs) model_start(addr, md, !wr);
    else if (!adv && (!m_write || !bwr)) m_pos = (m_pos + 1) % NB;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle_adv(bit bwr, string tag);
    step(1, 1, 1, 0, 0, bwr, 0, tag);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_errs++;
    n_checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin : main
    model_start(0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");
    idle_adv(1, "R1 linear read after reset");

    // R5: interleaved from start 1 -> 1,0,3,2 then wrap (R8)
    step(1, 0, 1, 'h1235, 1, 1, 1, "R2 load");
    idle_adv(1, "R5 beat1");
    idle_adv(1, "R5 beat2");
    idle_adv(1, "R5 beat3");
    idle_adv(1, "R8 wrap to start");

    // R6: linear from start 1 -> 1,2,3,0
    step(0, 1, 1, 'h2A01, 1, 1, 0, "R2 load");
    idle_adv(1, "R6 beat1");
    idle_adv(1, "R6 beat2");
    idle_adv(1, "R6 beat3");
    idle_adv(1, "R8 wrap to start");

    // R3: adv_n low on the load edge is ignored
    step(0, 1, 1, 'h3003, 0, 0, 1, "R3 load with adv low");
    step(1, 1, 1, 0, 1, 1, 0, "R4 hold adv high");
    step(1, 0, 1, 'h0402, 0, 1, 0, "R4 strobe low reloads, no advance");
    step(1, 1, 1, 0, 1, 0, 1, "R4 hold");

    // R2 priority: both strobes low -> read burst, R10 wr_req ignored
    step(0, 0, 0, 'h1112, 1, 1, 0, "R2 both strobes");
    idle_adv(1, "R10 read advances with byte_wr high");

    // R9: write burst gating
    step(1, 0, 0, 'h0F01, 1, 1, 1, "R9 write load");
    idle_adv(1, "R9 byte strobe high holds");
    idle_adv(0, "R9 byte strobe low advances");
    step(1, 1, 1, 0, 1, 0, 0, "R9 byte low adv high holds");

    // R11: mode change mid-burst
    step(1, 0, 1, 'h0502, 1, 1, 0, "R2 load linear");
    step(1, 1, 1, 0, 0, 1, 1, "R11 mode flipped, stays linear");
    step(1, 1, 1, 0, 0, 1, 1, "R11 mode flipped, stays linear");

    // R7 and mixed traffic: random stimulus
    for (int i = 0; i < 3000; i++) begin
      bit ps, cs, wr, adv, bwr, md;
      int r;
      r   = $urandom_range(0, 99);
      ps  = (r >= 8);
      cs  = (r < 8 || r >= 16);
      wr  = $urandom_range(0, 1);
      adv = ($urandom_range(0, 3) == 0);
      bwr = $urandom_range(0, 1);
      md  = $urandom_range(0, 1);
      step(ps, cs, wr, int'($urandom_range(0, (1 << AW) - 1)), adv, bwr, md,
           (!ps || !cs) ? "R2 random load" : "R7 random beat");
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule